// File: doc/BRIEF.md
# ECC error capture and interrupt unit

This unit sits beside an error-correcting RAM controller and records what goes wrong in it. The controller reports single-bit (corrected) and double-bit (uncorrectable) read errors, each with the failing address and syndrome byte. The unit keeps one sticky status flag per error kind and a single capture record of the most important error seen. It drives one registered interrupt line that is gated by a per-kind enable.

Software talks to the unit through a four-word register port. Word 0 holds the interrupt enables. Word 1 holds the status flags, which are cleared by writing 1. Word 2 returns the captured address and word 3 the captured syndrome and error kind. A captured single error is frozen until its flag is cleared, unless a double error arrives first and takes the record. A captured double error is frozen until its own flag is cleared.

Top module: `ecc_err_capture`

## Requirements
- R1: While `ecc_dec_en` is low, `evt_sgl` and `evt_dbl` are ignored: they change no status flag and no capture field.
- R2: A qualified single event sets status bit 0 and a qualified double event sets status bit 1 (word 1) on the next clock edge. The bits stay set until cleared.
- R3: A write to word 1 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: If a clear and a new event for the same status bit fall in one cycle, the bit ends set.
- R5: A qualified single event with both status bits clear loads the capture record: word 2 = address, word 3 bits [7:0] = syndrome, word 3 bit 8 = 0.
- R6: While status bit 0 is set, a new single event keeps the bit set but leaves the capture record unchanged.
- R7: A qualified double event with status bit 1 clear loads the record with its address and syndrome and sets word 3 bit 8 = 1, even when a single-error record is held.
- R8: While status bit 1 is set, no single or double event changes the capture record.
- R9: A single and a double event in the same cycle set both status bits, and the double event is the one captured.
- R10: `irq` equals, one cycle later, the OR of (status bit 0 AND word 0 bit 0) and (status bit 1 AND word 0 bit 1). Word 0 is read/write.
- R11: After reset all four register words read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_dec_en | input | 1 | ECC decoding enabled; qualifies the events |
| evt_sgl | input | 1 | Single-bit error event, one cycle per event |
| evt_dbl | input | 1 | Double-bit error event, one cycle per event |
| evt_addr | input | ADDR_W | Address of the erroneous read |
| evt_syn | input | SYN_W | Syndrome of the erroneous read |
| reg_addr | input | 2 | Register word select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that the event, address and syndrome inputs hold known values at every clock edge. They also assume that the status flags can be lowered only through a write to word 1. The stimulus drives every input at the falling edge with values from a fixed-seed `$urandom`. It writes only to words 0 and 1. It mixes in directed sequences for same-cycle clear and event, simultaneous single and double events, and events while decoding is off.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_SGL = 0;
   localparam int unsigned SRC_DBL = 1;

   typedef enum logic [1:0] {
      REG_IRQ_EN   = 2'd0,
      REG_STATUS   = 2'd1,
      REG_CAP_ADDR = 2'd2,
      REG_CAP_INFO = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ecc_sticky_bit.sv
module ecc_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/ecc_capture_rec.sv
module ecc_capture_rec #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SYN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sgl_i,
   input  logic              dbl_i,
   input  logic              sgl_held_i,
   input  logic              dbl_held_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SYN_W-1:0]  syn_i,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic [SYN_W-1:0]  cap_syn_o,
   output logic              cap_dbl_o
);
   logic load_dbl, load_sgl;

   // a double may displace a held single; nothing displaces a held double
   assign load_dbl = dbl_i && !dbl_held_i;
   assign load_sgl = sgl_i && !sgl_held_i && !dbl_held_i && !dbl_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_addr_o <= '0;
         cap_syn_o  <= '0;
         cap_dbl_o  <= 1'b0;
      end else if (load_dbl || load_sgl) begin
         cap_addr_o <= addr_i;
         cap_syn_o  <= syn_i;
         cap_dbl_o  <= load_dbl;
      end
   end
endmodule

// File: rtl/ecc_irq_gen.sv
module ecc_irq_gen #(
   parameter int unsigned NSRC    = 2,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] sts_i,
   input  logic [NSRC-1:0] en_i,
   output logic            irq_o
);
   logic pend;
   assign pend = |(sts_i & en_i);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= pend;
         end
      end else begin : g_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_cap_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SYN_W   = 8,
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_dec_en,
   input  logic              evt_sgl,
   input  logic              evt_dbl,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic [SYN_W-1:0]  evt_syn,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned INFO_W = SYN_W + 1;

   generate
      if (ADDR_W > DATA_W || ADDR_W == 0) begin : g_bad_addr
         $error("ADDR_W must be 1..DATA_W");
      end
      if (INFO_W > DATA_W || SYN_W == 0) begin : g_bad_syn
         $error("SYN_W+1 must fit in DATA_W");
      end
      if (DATA_W < NUM_SRC) begin : g_bad_data
         $error("DATA_W too narrow");
      end
   endgenerate

   logic [NUM_SRC-1:0] set_v, clr_v, sts_q, en_q;
   logic [ADDR_W-1:0]  cap_addr_q;
   logic [SYN_W-1:0]   cap_syn_q;
   logic               cap_dbl_q;
   reg_sel_e           sel;

   assign sel = reg_sel_e'(reg_addr);

   assign set_v[SRC_SGL] = evt_sgl && ecc_dec_en;
   assign set_v[SRC_DBL] = evt_dbl && ecc_dec_en;
   assign clr_v = (reg_we && sel == REG_STATUS) ? reg_wdata[NUM_SRC-1:0] : '0;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_sts
         ecc_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (sts_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                         en_q <= '0;
      else if (reg_we && sel == REG_IRQ_EN) en_q <= reg_wdata[NUM_SRC-1:0];
   end

   ecc_capture_rec #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sgl_i      (set_v[SRC_SGL]),
      .dbl_i      (set_v[SRC_DBL]),
      .sgl_held_i (sts_q[SRC_SGL]),
      .dbl_held_i (sts_q[SRC_DBL]),
      .addr_i     (evt_addr),
      .syn_i      (evt_syn),
      .cap_addr_o (cap_addr_q),
      .cap_syn_o  (cap_syn_q),
      .cap_dbl_o  (cap_dbl_q)
   );

   ecc_irq_gen #(.NSRC(NUM_SRC), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .sts_i (sts_q),
      .en_i  (en_q),
      .irq_o (irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         REG_IRQ_EN:   reg_rdata[NUM_SRC-1:0] = en_q;
         REG_STATUS:   reg_rdata[NUM_SRC-1:0] = sts_q;
         REG_CAP_ADDR: reg_rdata[ADDR_W-1:0]  = cap_addr_q;
         REG_CAP_INFO: reg_rdata[INFO_W-1:0]  = {cap_dbl_q, cap_syn_q};
         default:      reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SYN_W   = 8,
   parameter bit          IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ecc_dec_en,
   input logic              evt_sgl,
   input logic              evt_dbl,
   input logic [ADDR_W-1:0] evt_addr,
   input logic [1:0]        reg_addr,
   input logic              reg_we,
   input logic [1:0]        sts_q,
   input logic [1:0]        en_q,
   input logic [ADDR_W-1:0] cap_addr_q,
   input logic [SYN_W-1:0]  cap_syn_q,
   input logic              cap_dbl_q,
   input logic              irq
);
   // R2
   sgl_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sgl && ecc_dec_en) |=> sts_q[0]);

   // R2
   dbl_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_dbl && ecc_dec_en) |=> sts_q[1]);

   // R1
   gated_events_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_dec_en && !(reg_we && reg_addr == 2'd1)) |=> $stable(sts_q));

   // R7
   dbl_takes_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_dbl && ecc_dec_en && !sts_q[1]) |=> (cap_dbl_q && cap_addr_q == $past(evt_addr)));

   // R8
   dbl_record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_q[1] |=> ($stable(cap_addr_q) && $stable(cap_syn_q) && $stable(cap_dbl_q)));

   // R6
   sgl_record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[0] && !(evt_dbl && ecc_dec_en)) |=> ($stable(cap_addr_q) && $stable(cap_syn_q)));

   generate
      if (IRQ_REG) begin : g_irq_chk
         // R10
         irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq == $past(|(sts_q & en_q))));
      end
   endgenerate
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
   .ADDR_W(ADDR_W), .SYN_W(SYN_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ecc_dec_en(ecc_dec_en), .evt_sgl(evt_sgl),
   .evt_dbl(evt_dbl), .evt_addr(evt_addr), .reg_addr(reg_addr), .reg_we(reg_we),
   .sts_q(sts_q), .en_q(en_q), .cap_addr_q(cap_addr_q), .cap_syn_q(cap_syn_q),
   .cap_dbl_q(cap_dbl_q), .irq(irq)
);

// File: tb/ecc_err_capture_bench.sv
module ecc_err_capture_bench;
   localparam int CLK_PERIOD = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_dec_en = 1'b0, evt_sgl = 1'b0, evt_dbl = 1'b0;
   logic [31:0] evt_addr = '0;
   logic [7:0]  evt_syn = '0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0, fails = 0;

   // reference state
   logic [1:0]  m_sts = '0, m_en = '0;
   logic [31:0] m_addr = '0;
   logic [7:0]  m_syn = '0;
   logic        m_dbl = 1'b0, m_irq = 1'b0;

   ecc_err_capture u_ecc_err_capture (
      .clk(clk), .rst_n(rst_n), .ecc_dec_en(ecc_dec_en), .evt_sgl(evt_sgl),
      .evt_dbl(evt_dbl), .evt_addr(evt_addr), .evt_syn(evt_syn),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 200000);
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   function automatic logic [31:0] info_word(input logic d, input logic [7:0] s);
      return {23'd0, d, s};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic rd_all(input string req);
      rd(2'd0, {30'd0, m_en}, req);
      rd(2'd1, {30'd0, m_sts}, req);
      rd(2'd2, m_addr, req);
      rd(2'd3, info_word(m_dbl, m_syn), req);
   endtask

   // drive one cycle of stimulus just after a falling edge, update the model at the rising edge
   task automatic step(input logic s, input logic d, input logic de,
                       input logic [31:0] a, input logic [7:0] sy,
                       input logic we, input logic [1:0] wa, input logic [31:0] wd,
                       input string req);
      logic qs, qd;
      logic [1:0] clr;
      evt_sgl = s; evt_dbl = d; ecc_dec_en = de; evt_addr = a; evt_syn = sy;
      reg_we = we; reg_addr = wa; reg_wdata = wd;
      @(posedge clk);
      qs = s & de; qd = d & de;
      m_irq = |(m_sts & m_en);
      if (qd && !m_sts[1]) begin
         m_addr = a; m_syn = sy; m_dbl = 1'b1;
      end else if (qs && !m_sts[0] && !m_sts[1]) begin
         m_addr = a; m_syn = sy; m_dbl = 1'b0;
      end
      clr = (we && wa == 2'd1) ? wd[1:0] : 2'b00;
      if (we && wa == 2'd0) m_en = wd[1:0];
      m_sts = (m_sts & ~clr) | {qd, qs};
      @(negedge clk);
      evt_sgl = 1'b0; evt_dbl = 1'b0; reg_we = 1'b0;
      #1;
      check(req, {31'd0, irq}, {31'd0, m_irq});
   endtask

   task automatic idle(input string req);
      step(0, 0, 1, '0, '0, 0, 2'd0, '0, req);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check("R11 irq", {31'd0, irq}, 32'd0);
      rd_all("R11");

      // R1 events ignored while decoding off
      step(1, 1, 0, 32'hDEAD_0001, 8'h11, 0, 2'd0, 0, "R1");
      rd_all("R1");

      // R5 single capture, R2 flag
      step(1, 0, 1, 32'h0000_1000, 8'h5A, 0, 2'd0, 0, "R5");
      rd_all("R5");
      // R6 second single frozen out
      step(1, 0, 1, 32'h0000_2000, 8'h33, 0, 2'd0, 0, "R6");
      rd_all("R6");
      // R10 enable single source, irq one cycle later
      step(0, 0, 1, '0, '0, 1, 2'd0, 32'h1, "R10");
      idle("R10");
      check("R10 irq high", {31'd0, irq}, 32'd1);
      // R7 double displaces held single
      step(0, 1, 1, 32'h0000_3000, 8'hC3, 0, 2'd0, 0, "R7");
      rd_all("R7");
      // R8 later single and double frozen out
      step(1, 0, 1, 32'h0000_4000, 8'h01, 0, 2'd0, 0, "R8");
      step(0, 1, 1, 32'h0000_5000, 8'h02, 0, 2'd0, 0, "R8");
      rd_all("R8");
      // R3 clear only bit 0: record stays (double held)
      step(0, 0, 1, '0, '0, 1, 2'd1, 32'h1, "R3");
      rd_all("R3");
      // R4 clear double with same-cycle double event: bit stays
      step(0, 1, 1, 32'h0000_6000, 8'h03, 1, 2'd1, 32'h2, "R4");
      rd_all("R4");
      // clear all, then R9 simultaneous events
      step(0, 0, 1, '0, '0, 1, 2'd1, 32'h3, "R3");
      rd_all("R3 cleared");
      step(1, 1, 1, 32'h0000_7000, 8'h77, 0, 2'd0, 0, "R9");
      rd_all("R9");
      // R10 double enable only
      step(0, 0, 1, '0, '0, 1, 2'd0, 32'h2, "R10");
      idle("R10");
      step(0, 0, 1, '0, '0, 1, 2'd1, 32'h3, "R10");
      idle("R10");
      check("R10 irq low", {31'd0, irq}, 32'd0);

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic de, s, d, we;
         de = ($urandom % 4) != 0;
         s  = ($urandom % 3) == 0;
         d  = ($urandom % 7) == 0;
         we = ($urandom % 4) == 0;
         step(s, d, de, $urandom, 8'($urandom), we, 2'($urandom % 2), $urandom, "R10 rand");
         if (i % 8 == 7) rd_all("R2 rand");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule